// File: doc/BRIEF.md
# Serial Audio DAC Output Interface

This block feeds stereo audio samples to an external digital-to-analog converter over four wires. These are a bit clock, a serial data line, a channel-select (word) clock, and an oversampling system clock at twice the bit-clock rate. All four are produced from the block's own clock, so they stay phase-locked to each other. Software or a sequencer writes sample words through a simple register port. The block transmits them one per channel slot, alternating left then right, most significant bit first.

Each channel slot is 32 bit-clock periods long. A 5-bit justification offset sets how many bit periods pass between the channel-select edge and the first data bit. An offset of one gives I2S framing and zero gives left-justified framing. An offset of sixteen with 16-bit samples gives right-justified framing. A polarity bit chooses which channel-select level means left. A size bit chooses between 16-bit and 32-bit samples, and short samples are zero-padded around the justified position. A one-entry sample buffer drives a request flag. When a slot starts with the buffer empty, an underrun flag is raised and the previous sample is sent again. The flags can be masked onto an interrupt line.

Top module: `aud_ser_out`

## Requirements
- R1: While running, the data line changes only on a falling bit-clock edge and is meant to be sampled on the rising edge. Each channel slot is 32 bit periods long, and samples go out most significant bit first. The bit clock idles low.
- R2: With the polarity bit (CTRL bit 1) at 0, channel select is low during the left slot and high during the right slot. With the bit at 1, both levels are inverted. Channel select changes only at slot boundaries.
- R3: The justification offset J (CTRL bits 12:8) places the first sample bit at slot position J, where position 0 is the first bit period after the channel-select edge. Positions before J and positions after the last sample bit carry 0. Bits that would fall past the end of the slot are dropped.
- R4: With the size bit (CTRL bit 2) at 0, only bits 15:0 of a written word are sent, and bits 31:16 have no effect. With the size bit at 1, all 32 bits are sent.
- R5: With divider value d (CLKDIV bits 4:0), the system clock period is 2(d+1) input clocks and the bit-clock period is 4(d+1) input clocks.
- R6: A write to DATA (address 2) fills a one-entry buffer, and each slot start moves the buffer into the shifter. The first slot after enable (CTRL bit 0) is a left slot.
- R7: STATUS (address 3) bit 0 is the request flag. It reads 1 exactly when the sample buffer is empty.
- R8: STATUS bit 1 is the underrun flag. It is set when a slot starts with an empty buffer, and in that case the last sample sent is repeated. The flag stays set until STATUS is read, and a read returns the flag and then clears it.
- R9: STATUS bit 2 is the busy flag. Clearing enable lets the current frame finish through its right slot. The block then stops, with busy low, the bit clock low, the data line low, and channel select at the left level.
- R10: The irq output is the OR of the three status flags, each ANDed with its bit in MASK (address 4, bits 2:0).
- R11: After reset, all control fields, the divider and the mask are zero. The buffer is empty, and all four audio outputs and irq are low. Register reads return data one clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| irq | output | 1 | Masked status interrupt |
| aud_sclk | output | 1 | Oversampling system clock |
| aud_bclk | output | 1 | Serial bit clock |
| aud_dout | output | 1 | Serial data |
| aud_dsel | output | 1 | Channel select |

## Verification
A table of frames covers six settings: I2S 16-bit, left-justified 16-bit with inverted polarity, right-justified 16-bit, left-justified 32-bit, I2S 32-bit with a dropped final bit, and an offset of 31. Each frame uses left and right words whose bit patterns differ. An ordering, offset or truncation error therefore shows up as a mismatch in the captured 64-bit stream. Set upper halves in the 16-bit words separate sample-size handling from justification. Directed runs measure the clock periods with a non-zero divider. They also starve the right slot to show the repeat and the sticky underrun flag, and they check the stop sequence, the idle levels and the masked interrupt.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_CLKDIV = 3'd1,
    REG_DATA   = 3'd2,
    REG_STATUS = 3'd3,
    REG_MASK   = 3'd4
  } reg_addr_e;

  localparam int ST_REQ  = 0;
  localparam int ST_UNR  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_W    = 3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_POL  = 1;
  localparam int CTRL_SIZE = 2;
  localparam int CTRL_JUST = 8;
endpackage

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bclk,
  output logic             sclk,
  output logic             fall_ev
);
  logic [DIV_W-1:0] divcnt_q, divcnt_d;
  logic [1:0]       ph_q, ph_d;
  logic             tick;

  always_comb begin
    tick     = run && (divcnt_q == div);
    divcnt_d = divcnt_q;
    ph_d     = ph_q;
    if (!run) begin
      divcnt_d = '0;
      ph_d     = '0;
    end else if (tick) begin
      divcnt_d = '0;
      ph_d     = ph_q + 2'd1;
    end else begin
      divcnt_d = divcnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt_q <= '0;
      ph_q     <= '0;
    end else begin
      divcnt_q <= divcnt_d;
      ph_q     <= ph_d;
    end
  end

  assign fall_ev = tick && (ph_q == 2'd3);
  assign bclk    = ph_q[1];
  assign sclk    = ph_q[0];

  AST_SCLK_WITH_BCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $fell(sclk)); // R5
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> (!bclk && !sclk)); // R9
endmodule

// File: rtl/aud_serializer.sv
module aud_serializer #(
  parameter int DATA_W = 32,
  parameter int JUST_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pol,
  input  logic              size32,
  input  logic [JUST_W-1:0] just,
  input  logic              pend_full,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              fall_ev,
  input  logic              bclk,
  output logic              run,
  output logic              dout,
  output logic              dsel,
  output logic              load,
  output logic              underrun_ev
);
  localparam int POS_W = JUST_W + 1;
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [POS_W-1:0] POS_LAST = '1;
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);
  localparam logic [POS_W-1:0] LEN_FULL = POS_W'(DATA_W);
  localparam logic [POS_W-1:0] LEN_HALF = POS_W'(DATA_W / 2);

  logic              run_q, run_d;
  logic [POS_W-1:0]  pos_q, pos_d, npos;
  logic [DATA_W-1:0] cur_q, cur_d, nsamp;
  logic              dout_q, dout_d, dsel_q, dsel_d;
  logic              start, frame_end, stop, advance, slot_start;

  function automatic logic pick_bit(input logic [DATA_W-1:0] s,
                                    input logic [JUST_W-1:0] p,
                                    input logic [JUST_W-1:0] j,
                                    input logic sz);
    logic [POS_W-1:0] idx, lim, top;
    lim = sz ? LEN_FULL : LEN_HALF;
    idx = {1'b0, p} - {1'b0, j};
    top = lim - POS_ONE - idx;
    if ((p >= j) && (idx < lim)) return s[top[IDX_W-1:0]];
    return 1'b0;
  endfunction

  always_comb begin
    start      = en && !run_q;
    frame_end  = fall_ev && (pos_q == POS_LAST);
    stop       = frame_end && !en;
    advance    = start || (fall_ev && !stop);
    npos       = start ? '0 : pos_q + POS_ONE;
    slot_start = advance && (npos[JUST_W-1:0] == '0);
    load       = slot_start && pend_full;
    underrun_ev = slot_start && !pend_full;
    nsamp      = load ? pend_data : cur_q;

    run_d  = run_q;
    pos_d  = pos_q;
    cur_d  = cur_q;
    dout_d = dout_q;
    dsel_d = dsel_q;
    if (start) run_d = 1'b1;
    else if (stop) run_d = 1'b0;

    if (stop || (!run_q && !start)) begin
      pos_d  = '0;
      dout_d = 1'b0;
      dsel_d = pol;
    end else if (advance) begin
      pos_d  = npos;
      cur_d  = nsamp;
      dout_d = pick_bit(nsamp, npos[JUST_W-1:0], just, size32);
      dsel_d = npos[JUST_W] ^ pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      cur_q  <= '0;
      dout_q <= 1'b0;
      dsel_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pos_q  <= pos_d;
      cur_q  <= cur_d;
      dout_q <= dout_d;
      dsel_q <= dsel_d;
    end
  end

  assign run  = run_q;
  assign dout = dout_q;
  assign dsel = dsel_q;

  AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$stable(dout_q)) |-> $fell(bclk)); // R1
  AST_DSEL_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$stable(dsel_q)) |-> $fell(bclk)); // R2
endmodule

// File: rtl/aud_regs.sv
module aud_regs #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int JUST_W = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [aud_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      load,
  input  logic                      underrun_ev,
  input  logic                      busy,
  output logic [DATA_W-1:0]         rdata,
  output logic                      en,
  output logic                      pol,
  output logic                      size32,
  output logic [JUST_W-1:0]         just,
  output logic [DIV_W-1:0]          div,
  output logic                      pend_full,
  output logic [DATA_W-1:0]         pend_data,
  output logic                      irq
);
  import aud_pkg::*;

  logic              en_q, pol_q, size_q, en_d, pol_d, size_d;
  logic [JUST_W-1:0] just_q, just_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [ST_W-1:0]   mask_q, mask_d, status;
  logic [DATA_W-1:0] pend_q, pend_d, rdata_q, rdata_d, rd_mux;
  logic              full_q, full_d, unr_q, unr_d;
  logic              wr_ctrl, wr_div, wr_data, wr_mask, rd_stat;

  always_comb begin
    wr_ctrl = wr_en && (addr == REG_CTRL);
    wr_div  = wr_en && (addr == REG_CLKDIV);
    wr_data = wr_en && (addr == REG_DATA);
    wr_mask = wr_en && (addr == REG_MASK);
    rd_stat = rd_en && (addr == REG_STATUS);

    status          = '0;
    status[ST_REQ]  = !full_q;
    status[ST_UNR]  = unr_q;
    status[ST_BUSY] = busy;

    en_d   = wr_ctrl ? wdata[CTRL_EN]   : en_q;
    pol_d  = wr_ctrl ? wdata[CTRL_POL]  : pol_q;
    size_d = wr_ctrl ? wdata[CTRL_SIZE] : size_q;
    just_d = wr_ctrl ? wdata[CTRL_JUST +: JUST_W] : just_q;
    div_d  = wr_div  ? wdata[DIV_W-1:0] : div_q;
    mask_d = wr_mask ? wdata[ST_W-1:0]  : mask_q;
    pend_d = wr_data ? wdata : pend_q;
    full_d = wr_data ? 1'b1 : (load ? 1'b0 : full_q);
    unr_d  = underrun_ev ? 1'b1 : (rd_stat ? 1'b0 : unr_q);

    rd_mux = '0;
    case (addr)
      REG_CTRL: begin
        rd_mux[CTRL_EN]   = en_q;
        rd_mux[CTRL_POL]  = pol_q;
        rd_mux[CTRL_SIZE] = size_q;
        rd_mux[CTRL_JUST +: JUST_W] = just_q;
      end
      REG_CLKDIV: rd_mux[DIV_W-1:0] = div_q;
      REG_STATUS: rd_mux[ST_W-1:0]  = status;
      REG_MASK:   rd_mux[ST_W-1:0]  = mask_q;
      default:    rd_mux = '0;
    endcase
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pol_q   <= 1'b0;
      size_q  <= 1'b0;
      just_q  <= '0;
      div_q   <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      full_q  <= 1'b0;
      unr_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      pol_q   <= pol_d;
      size_q  <= size_d;
      just_q  <= just_d;
      div_q   <= div_d;
      mask_q  <= mask_d;
      pend_q  <= pend_d;
      full_q  <= full_d;
      unr_q   <= unr_d;
      rdata_q <= rdata_d;
    end
  end

  assign en        = en_q;
  assign pol       = pol_q;
  assign size32    = size_q;
  assign just      = just_q;
  assign div       = div_q;
  assign pend_full = full_q;
  assign pend_data = pend_q;
  assign rdata     = rdata_q;
  assign irq       = |(status & mask_q);

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> full_q); // R6
  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_ev |=> unr_q); // R8
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unr_q && !rd_stat) |=> unr_q); // R8
endmodule

// File: rtl/aud_ser_out.sv
module aud_ser_out #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 5,
  parameter int JUST_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [aud_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq,
  output logic                       aud_sclk,
  output logic                       aud_bclk,
  output logic                       aud_dout,
  output logic                       aud_dsel
);
  logic [1:0]        rsync_q;
  logic              rst_s;
  logic              en, pol, size32, pend_full, load, underrun_ev, run, fall_ev;
  logic [JUST_W-1:0] just;
  logic [DIV_W-1:0]  div;
  logic [DATA_W-1:0] pend_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s = rsync_q[1];

  aud_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .JUST_W(JUST_W)) regs_i (
    .clk(clk), .rst_n(rst_s), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .load(load), .underrun_ev(underrun_ev), .busy(run),
    .rdata(bus_rdata), .en(en), .pol(pol), .size32(size32), .just(just),
    .div(div), .pend_full(pend_full), .pend_data(pend_data), .irq(irq)
  );

  aud_clkgen #(.DIV_W(DIV_W)) clkgen_i (
    .clk(clk), .rst_n(rst_s), .run(run), .div(div),
    .bclk(aud_bclk), .sclk(aud_sclk), .fall_ev(fall_ev)
  );

  aud_serializer #(.DATA_W(DATA_W), .JUST_W(JUST_W)) ser_i (
    .clk(clk), .rst_n(rst_s), .en(en), .pol(pol), .size32(size32), .just(just),
    .pend_full(pend_full), .pend_data(pend_data), .fall_ev(fall_ev),
    .bclk(aud_bclk), .run(run), .dout(aud_dout), .dsel(aud_dsel),
    .load(load), .underrun_ev(underrun_ev)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s)
    !run |-> (!aud_bclk && !aud_dout)); // R9
endmodule

// File: tb/aud_ser_out_tb.sv
module aud_ser_out_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, aud_sclk, aud_bclk, aud_dout, aud_dsel;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  aud_ser_out dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .aud_sclk(aud_sclk), .aud_bclk(aud_bclk),
    .aud_dout(aud_dout), .aud_dsel(aud_dsel)
  );

  typedef struct packed {
    logic [4:0]  j;
    logic        sz;
    logic        pol;
    logic [31:0] left;
    logic [31:0] right;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{j: 5'd1,  sz: 1'b0, pol: 1'b0, left: 32'hFFFF_A5C3, right: 32'h0000_1E0F},
    '{j: 5'd0,  sz: 1'b0, pol: 1'b1, left: 32'h1234_8001, right: 32'hABCD_7FFE},
    '{j: 5'd16, sz: 1'b0, pol: 1'b0, left: 32'h5555_C0DE, right: 32'h0F0F_0421},
    '{j: 5'd0,  sz: 1'b1, pol: 1'b0, left: 32'h8000_0001, right: 32'h7FFF_FFFE},
    '{j: 5'd1,  sz: 1'b1, pol: 1'b1, left: 32'hC3A5_9669, right: 32'h0123_4567},
    '{j: 5'd31, sz: 1'b0, pol: 1'b0, left: 32'h0000_8000, right: 32'hFFFF_7FFF}
  };

  logic        cap_on = 1'b0;
  int          cap_cnt = 0;
  logic [63:0] cap_d, cap_s;
  logic        bclk_prev = 1'b0;

  always @(negedge clk) begin
    if (!cap_on) cap_cnt = 0;
    else if (aud_bclk && !bclk_prev && cap_cnt < 64) begin
      cap_d[63-cap_cnt] = aud_dout;
      cap_s[63-cap_cnt] = aud_dsel;
      cap_cnt = cap_cnt + 1;
    end
    bclk_prev = aud_bclk;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  function automatic logic ebit(input logic [31:0] s, input int b, input int j, input logic sz);
    int len = sz ? 32 : 16;
    int k = b - j;
    if (k < 0 || k >= len) return 1'b0;
    return s[len-1-k];
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [4:0] j, input logic sz, input logic pol, input logic en);
    return {19'd0, j, 5'd0, sz, pol, en};
  endfunction

  task automatic play(input vec_t v, input bit write_right);
    cap_on = 1'b0;
    wr(3'd0, ctrl_word(v.j, v.sz, v.pol, 1'b0));
    wr(3'd2, v.left);
    @(negedge clk);
    cap_on = 1'b1;
    wr(3'd0, ctrl_word(v.j, v.sz, v.pol, 1'b1));
    repeat (3) @(negedge clk);
    if (write_right) wr(3'd2, v.right);
    wr(3'd0, ctrl_word(v.j, v.sz, v.pol, 1'b0));
    while (cap_cnt < 64) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_frame(input vec_t v, input logic [31:0] rsamp, input string rq);
    logic [63:0] ed, es;
    for (int b = 0; b < 64; b++) begin
      ed[63-b] = ebit((b < 32) ? v.left : rsamp, b % 32, int'(v.j), v.sz);
      es[63-b] = (b >= 32) ^ v.pol;
    end
    chk(cap_d == ed, {rq, " data stream"}, cap_d, ed);
    chk(cap_s == es, "R2 channel select", cap_s, es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1..all actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int n;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    chk({aud_sclk, aud_bclk, aud_dout, aud_dsel, irq} == 5'b0, "R11 outputs after reset",
        {59'd0, aud_sclk, aud_bclk, aud_dout, aud_dsel, irq}, 64'd0);
    rd(3'd0, rv);
    chk(rv == 32'd0, "R11 control after reset", {32'd0, rv}, 64'd0);
    rd(3'd3, rv);
    chk(rv == 32'd1, "R7 status after reset", {32'd0, rv}, 64'd1);

    // R10: masked request interrupt
    wr(3'd4, 32'd1);
    chk(irq == 1'b1, "R10 irq with request masked in", {63'd0, irq}, 64'd1);
    wr(3'd2, 32'hDEAD_BEEF);
    chk(irq == 1'b0, "R10 irq after buffer filled", {63'd0, irq}, 64'd0);
    rd(3'd3, rv);
    chk(rv[0] == 1'b0, "R7 request clear when buffer full", {63'd0, rv[0]}, 64'd0);
    wr(3'd4, 32'd0);

    // R1 R3 R4 R6: table of frames
    for (int i = 0; i < NVEC; i++) begin
      play(VECS[i], 1'b1);
      expect_frame(VECS[i], VECS[i].right, "R1 R3 R4 R6");
    end
    rd(3'd3, rv);
    chk(rv[2:0] == 3'b001, "R8 no underrun when fed", {61'd0, rv[2:0]}, 64'd1);

    // R8: right slot starved, left sample repeats, flag sticky then cleared by read
    play(VECS[0], 1'b0);
    expect_frame(VECS[0], VECS[0].left, "R8 repeat");
    rd(3'd3, rv);
    chk(rv[2:0] == 3'b011, "R8 underrun set", {61'd0, rv[2:0]}, 64'd3);
    rd(3'd3, rv);
    chk(rv[1] == 1'b0, "R8 underrun cleared by read", {63'd0, rv[1]}, 64'd0);

    // R5 R9: divider 2, polarity 1
    wr(3'd1, 32'd2);
    wr(3'd0, ctrl_word(5'd0, 1'b0, 1'b1, 1'b0));
    wr(3'd2, 32'h0000_F00F);
    wr(3'd0, ctrl_word(5'd0, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
    while (!aud_bclk) @(negedge clk);
    n = 0;
    while (aud_bclk) begin @(negedge clk); n++; end
    while (!aud_bclk) begin @(negedge clk); n++; end
    chk(n == 12, "R5 bit clock period", 64'(n), 64'd12);
    while (!aud_sclk) @(negedge clk);
    n = 0;
    while (aud_sclk) begin @(negedge clk); n++; end
    while (!aud_sclk) begin @(negedge clk); n++; end
    chk(n == 6, "R5 system clock period", 64'(n), 64'd6);
    rd(3'd3, rv);
    chk(rv[2] == 1'b1, "R9 busy while running", {63'd0, rv[2]}, 64'd1);
    wr(3'd0, ctrl_word(5'd0, 1'b0, 1'b1, 1'b0));
    repeat (900) @(negedge clk);
    rd(3'd3, rv);
    chk(rv[2] == 1'b0, "R9 busy low after stop", {63'd0, rv[2]}, 64'd0);
    chk({aud_bclk, aud_sclk, aud_dout, aud_dsel} == 4'b0001, "R9 idle levels",
        {60'd0, aud_bclk, aud_sclk, aud_dout, aud_dsel}, 64'd1);
    rd(3'd1, rv);
    chk(rv == 32'd2, "R5 divider readback", {32'd0, rv}, 64'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule